// File: doc/BRIEF.md
# TileLink Host Request Mapper

This block sits between a host that speaks a plain request/response handshake and a TileLink link. A request is offered with valid/ready, an address, a write-data word, a byte mask and a write flag. The block turns it into an A-channel message, then waits for the matching D-channel reply and hands the reply data back with a one-cycle response strobe. Only one transaction is in flight at a time. The host may start the next request only after the last response of the current one has been delivered.

Five qualifier inputs sit beside the plain request: an arithmetic flag, a logical flag, an intent flag, a 3-bit operation parameter and a log2 byte-count size. A heavyweight-mode input gates them. When it is low the qualifiers are ignored and the block issues only reads and writes at full bus width. When it is high the qualifiers select atomic, hint and sized transfers. In that mode a write wider than the data bus becomes a multi-beat burst, and the host supplies each further beat over the same request handshake. A read wider than the bus returns several D beats, each delivered as its own response strobe.

Top module: `tl_host_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `a_valid`, `d_ready` and `rsp_valid` are 0.
- R2: With `hw_mode` 0 every qualifier is ignored. A read issues opcode 4 with param 0. A write issues opcode 0 when all `req_mask` bits are 1 and opcode 1 otherwise. `a_size` is log2 of the bus byte width (2 for a 32-bit bus).
- R3: With `hw_mode` 1 the flags are ranked arithmetic first, then logical, then intent, then plain read/write. The arithmetic flag gives opcode 2 and the logical flag gives opcode 3, and each passes `q_param` to `a_param` unchanged.
- R4: With `hw_mode` 1 and only the intent flag among the three, the opcode is 5 and `a_param` is `q_param[0]` (0 = prefetch for read, 1 = prefetch for write). The single D reply is delivered as the response.
- R5: With `hw_mode` 1, `a_size` equals `q_size`. A write with `q_size` at or below the bus width is one beat, and its opcode is chosen by the mask as in R2.
- R6: With `hw_mode` 1, a write with `q_size` above the bus width is sent as 2^(q_size - log2 bytes) A beats. After the first beat is sent, `req_ready` rises to take each further beat's `req_wdata` and `req_mask`. Opcode, param, size, source and address stay the same on every beat. One D reply closes the burst.
- R7: With `hw_mode` 1, a read with `q_size` above the bus width expects 2^(q_size - log2 bytes) D beats. Each beat produces one `rsp_valid` pulse carrying that beat's data.
- R8: From acceptance until the cycle after the last response pulse, `req_ready` is 0 except while a further burst beat is being taken. `d_ready` is never 1 while an A beat is pending or while `req_ready` is 1.
- R9: While `a_valid` is 1 and `a_ready` is 0, `a_valid` stays 1 and every A-channel field holds its value.
- R10: `rsp_valid` rises only in the cycle after a D handshake, and `rsp_data` then equals the `d_data` of that handshake. `d_valid` offered earlier than that is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_mode | input | 1 | Enables the qualifier inputs |
| req_valid | input | 1 | Host request or burst beat valid |
| req_ready | output | 1 | Mapper can take a request or burst beat |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data for the current beat |
| req_mask | input | DATA_W/8 | Byte mask for the current beat |
| q_arith | input | 1 | Arithmetic atomic qualifier |
| q_logic | input | 1 | Logical atomic qualifier |
| q_intent | input | 1 | Hint (intent) qualifier |
| q_param | input | 3 | Atomic sub-operation or prefetch kind |
| q_size | input | SIZE_W | log2 of transfer byte count |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Response data |
| a_valid | output | 1 | A-channel valid |
| a_ready | input | 1 | A-channel ready |
| a_opcode | output | 3 | A-channel opcode |
| a_param | output | 3 | A-channel param |
| a_size | output | SIZE_W | A-channel size |
| a_source | output | SRC_W | A-channel source id (constant) |
| a_address | output | ADDR_W | A-channel address |
| a_mask | output | DATA_W/8 | A-channel byte mask |
| a_data | output | DATA_W | A-channel data |
| d_valid | input | 1 | D-channel valid |
| d_ready | output | 1 | D-channel ready |
| d_data | input | DATA_W | D-channel data |

## Verification
Two things can coincide. A responder may present `d_valid` while the A beat is still pending, and the host may already hold the next `req_valid` during the response strobe. The bench provokes both at once: it raises `d_valid` and the next request together with the first. It then checks cycle by cycle that the reply is taken only after the A handshake, that the response strobe carries that reply, and that the waiting request is accepted only in the cycle after the strobe.

// File: rtl/tl_host_mapper.sv
module tl_host_mapper #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int SRC_W     = 4,
  parameter int SOURCE_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_mode,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic                q_arith,
  input  logic                q_logic,
  input  logic                q_intent,
  input  logic [2:0]          q_param,
  input  logic [SIZE_W-1:0]   q_size,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                a_valid,
  input  logic                a_ready,
  output logic [2:0]          a_opcode,
  output logic [2:0]          a_param,
  output logic [SIZE_W-1:0]   a_size,
  output logic [SRC_W-1:0]    a_source,
  output logic [ADDR_W-1:0]   a_address,
  output logic [DATA_W/8-1:0] a_mask,
  output logic [DATA_W-1:0]   a_data,
  input  logic                d_valid,
  output logic                d_ready,
  input  logic [DATA_W-1:0]   d_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int LB    = $clog2(BYTES);
  localparam int CNT_W = (1 << SIZE_W) - LB;

  localparam logic [2:0] OP_PUTF  = 3'd0;
  localparam logic [2:0] OP_PUTP  = 3'd1;
  localparam logic [2:0] OP_ARITH = 3'd2;
  localparam logic [2:0] OP_LOGIC = 3'd3;
  localparam logic [2:0] OP_GET   = 3'd4;
  localparam logic [2:0] OP_HINT  = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_GATHER, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [2:0]          op_q, prm_q, dec_op, dec_prm;
  logic [SIZE_W-1:0]   sz_q, dec_sz;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q, rdata_q;
  logic [BYTES-1:0]    mask_q;
  logic [CNT_W-1:0]    a_left, d_left, span, dec_abeats, dec_dbeats;
  logic                hw_q;
  logic                put_op;

  wire mask_full = &req_mask;
  wire wr_op     = mask_full ? OP_PUTF : OP_PUTP;

  assign span = (q_size > SIZE_W'(LB))
              ? ((CNT_W'(1) << (q_size - SIZE_W'(LB))) - CNT_W'(1)) : '0;

  always_comb begin
    dec_op  = req_write ? (mask_full ? OP_PUTF : OP_PUTP) : OP_GET;
    dec_prm = 3'd0;
    dec_sz  = SIZE_W'(LB);
    if (hw_mode) begin
      dec_sz = q_size;
      if (q_arith) begin
        dec_op  = OP_ARITH;
        dec_prm = q_param;
      end else if (q_logic) begin
        dec_op  = OP_LOGIC;
        dec_prm = q_param;
      end else if (q_intent) begin
        dec_op  = OP_HINT;
        dec_prm = {2'b00, q_param[0]};
      end
    end
  end

  assign put_op     = (dec_op == OP_PUTF) || (dec_op == OP_PUTP);
  assign dec_abeats = (hw_mode && put_op) ? span : '0;
  assign dec_dbeats = (hw_mode && dec_op == OP_GET) ? span : '0;

  assign req_ready = (st == S_IDLE) || (st == S_GATHER);
  assign a_valid   = (st == S_SEND);
  assign d_ready   = (st == S_WAIT);
  assign rsp_valid = (st == S_RESP);
  assign rsp_data  = rdata_q;
  assign a_opcode  = op_q;
  assign a_param   = prm_q;
  assign a_size    = sz_q;
  assign a_source  = SRC_W'(SOURCE_ID);
  assign a_address = addr_q;
  assign a_mask    = mask_q;
  assign a_data    = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      prm_q   <= '0;
      sz_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      a_left  <= '0;
      d_left  <= '0;
      hw_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= dec_op;
          prm_q  <= dec_prm;
          sz_q   <= dec_sz;
          addr_q <= req_addr;
          data_q <= req_wdata;
          mask_q <= req_mask;
          hw_q   <= hw_mode;
          a_left <= dec_abeats;
          d_left <= dec_dbeats;
          st     <= S_SEND;
        end
        S_SEND: if (a_ready) begin
          if (a_left != '0) begin
            a_left <= a_left - CNT_W'(1);
            st     <= S_GATHER;
          end else begin
            st <= S_WAIT;
          end
        end
        S_GATHER: if (req_valid) begin
          data_q <= req_wdata;
          mask_q <= req_mask;
          st     <= S_SEND;
        end
        S_WAIT: if (d_valid) begin
          rdata_q <= d_data;
          st      <= S_RESP;
        end
        S_RESP: begin
          if (d_left != '0) begin
            d_left <= d_left - CNT_W'(1);
            st     <= S_WAIT;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^wr_op;
endmodule

// File: rtl/tl_host_mapper_chk.sv
module tl_host_mapper_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                a_valid,
  input logic                a_ready,
  input logic [2:0]          a_opcode,
  input logic [2:0]          a_param,
  input logic [SIZE_W-1:0]   a_size,
  input logic [ADDR_W-1:0]   a_address,
  input logic [DATA_W/8-1:0] a_mask,
  input logic [DATA_W-1:0]   a_data,
  input logic                d_valid,
  input logic                d_ready,
  input logic [DATA_W-1:0]   d_data,
  input logic                rsp_valid,
  input logic [DATA_W-1:0]   rsp_data,
  input logic                hw_q
);
  logic              seen_beat;
  logic [2:0]        held_op;
  logic [SIZE_W-1:0] held_sz;
  logic [ADDR_W-1:0] held_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_beat <= 1'b0;
      held_op   <= '0;
      held_sz   <= '0;
      held_addr <= '0;
    end else if (d_ready) begin
      seen_beat <= 1'b0;
    end else if (a_valid && a_ready && !seen_beat) begin
      seen_beat <= 1'b1;
      held_op   <= a_opcode;
      held_sz   <= a_size;
      held_addr <= a_address;
    end
  end

  p_lw_getput_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !hw_q |-> (a_opcode == 3'd0 || a_opcode == 3'd1 || a_opcode == 3'd4));

  p_burst_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && seen_beat |-> (a_opcode == held_op && a_size == held_sz && a_address == held_addr));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_ready && (req_ready || a_valid)));

  p_a_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_ready |=> a_valid && $stable(a_opcode) && $stable(a_param) &&
    $stable(a_size) && $stable(a_address) && $stable(a_data) && $stable(a_mask));

  p_rsp_after_d_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(d_valid && d_ready));

  p_rsp_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data == $past(d_data));
endmodule

bind tl_host_mapper tl_host_mapper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .a_valid(a_valid), .a_ready(a_ready),
  .a_opcode(a_opcode), .a_param(a_param), .a_size(a_size), .a_address(a_address),
  .a_mask(a_mask), .a_data(a_data), .d_valid(d_valid), .d_ready(d_ready), .d_data(d_data),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .hw_q(hw_q)
);

// File: tb/tl_host_mapper_test.sv
`timescale 1ns/1ps
module tl_host_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        q_arith = 1'b0, q_logic = 1'b0, q_intent = 1'b0;
  logic [2:0]  q_param = '0, q_size = '0;
  logic        a_ready = 1'b0, d_valid = 1'b0;
  logic [31:0] d_data = '0;
  logic        req_ready, rsp_valid, a_valid, d_ready;
  logic [31:0] rsp_data, a_address, a_data;
  logic [2:0]  a_opcode, a_param, a_size;
  logic [3:0]  a_source, a_mask;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tl_host_mapper uut (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .q_arith(q_arith), .q_logic(q_logic), .q_intent(q_intent), .q_param(q_param), .q_size(q_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .a_valid(a_valid), .a_ready(a_ready),
    .a_opcode(a_opcode), .a_param(a_param), .a_size(a_size), .a_source(a_source),
    .a_address(a_address), .a_mask(a_mask), .a_data(a_data), .d_valid(d_valid),
    .d_ready(d_ready), .d_data(d_data)
  );

  // hw wr ar lg in prm sz mask | exp op, exp prm, exp sz, beats
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,1'b0,3'd5,3'd5,4'hF, 3'd4,3'd0,3'd2,4'd1},
    {1'b0,1'b1,1'b0,1'b1,1'b1,3'd7,3'd4,4'hF, 3'd0,3'd0,3'd2,4'd1},
    {1'b0,1'b1,1'b1,1'b0,1'b0,3'd2,3'd5,4'h3, 3'd1,3'd0,3'd2,4'd1},
    {1'b1,1'b1,1'b1,1'b1,1'b1,3'd3,3'd2,4'hF, 3'd2,3'd3,3'd2,4'd1},
    {1'b1,1'b0,1'b0,1'b1,1'b1,3'd1,3'd2,4'hF, 3'd3,3'd1,3'd2,4'd1},
    {1'b1,1'b0,1'b0,1'b0,1'b1,3'd1,3'd4,4'hF, 3'd5,3'd1,3'd4,4'd1},
    {1'b1,1'b1,1'b0,1'b0,1'b1,3'd6,3'd2,4'hF, 3'd5,3'd0,3'd2,4'd1},
    {1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd2,4'hF, 3'd4,3'd0,3'd2,4'd1},
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,3'd4,4'hF, 3'd0,3'd0,3'd4,4'd4},
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,3'd3,4'h5, 3'd1,3'd0,3'd3,4'd2},
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,3'd1,4'h3, 3'd1,3'd0,3'd1,4'd1},
    {1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd4,4'hF, 3'd4,3'd0,3'd4,4'd4}
  };

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_req(input logic hw, input logic wr, input logic ar, input logic lg, input logic it,
                         input logic [2:0] prm, input logic [2:0] sz, input logic [3:0] msk,
                         input logic [31:0] addr, input logic [31:0] data);
    hw_mode = hw; req_write = wr; q_arith = ar; q_logic = lg; q_intent = it;
    q_param = prm; q_size = sz; req_mask = msk; req_addr = addr; req_wdata = data;
    req_valid = 1'b1;
  endtask

  task automatic run_vec(input logic [27:0] v, input int idx);
    logic [31:0] addr, data;
    int abeats, dbeats;
    string tag;
    addr = 32'h1000 + 32'(idx * 64);
    data = 32'hA000_0000 + 32'(idx << 8);
    tag  = (v[27] == 1'b0) ? "R2" : (v[12:10] == 3'd5) ? "R4" :
           (v[12:10] == 3'd2 || v[12:10] == 3'd3) ? "R3" : "R5";
    abeats = (v[12:10] == 3'd4) ? 1 : int'(v[3:0]);
    dbeats = (v[12:10] == 3'd4) ? int'(v[3:0]) : 1;
    @(negedge clk);
    set_req(v[27], v[26], v[25], v[24], v[23], v[22:20], v[19:17], v[16:13], addr, data);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < abeats; b++) begin
      while (!a_valid) @(negedge clk);
      chk(tag, "opcode", 64'(a_opcode), 64'(v[12:10]));
      chk(tag, "param", 64'(a_param), 64'(v[9:7]));
      chk(tag, "size", 64'(a_size), 64'(v[6:4]));
      chk(abeats > 1 ? "R6" : tag, "address", 64'(a_address), 64'(addr));
      chk("R6", "source", 64'(a_source), 64'd0);
      chk(abeats > 1 ? "R6" : tag, "beat data", 64'(a_data), 64'(data + 32'(b)));
      a_ready = 1'b1;
      @(negedge clk);
      a_ready = 1'b0;
      if (b < abeats - 1) begin
        chk("R6", "ready for next beat", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_wdata = data + 32'(b + 1);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    for (int db = 0; db < dbeats; db++) begin
      while (!d_ready) @(negedge clk);
      d_valid = 1'b1;
      d_data  = 32'h5000_0000 + 32'(idx * 16 + db);
      @(negedge clk);
      d_valid = 1'b0;
      chk(dbeats > 1 ? "R7" : "R10", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(dbeats > 1 ? "R7" : "R10", "rsp_data", 64'(rsp_data), 64'(32'h5000_0000 + 32'(idx * 16 + db)));
      chk("R8", "ready low during response", 64'(req_ready), 64'd0);
    end
    @(negedge clk);
    chk("R8", "ready after last response", 64'(req_ready), 64'd1);
    chk("R8", "no extra A beat", 64'(a_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held_addr;
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", 64'(req_ready), 64'd1);
    chk("R1", "a_valid in reset", 64'(a_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk("R1", "a_valid after reset", 64'(a_valid), 64'd0);
    chk("R1", "d_ready after reset", 64'(d_ready), 64'd0);
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R9: backpressure on an arithmetic request
    @(negedge clk);
    set_req(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 3'd2, 4'hF, 32'h3000, 32'h1234);
    @(negedge clk);
    req_valid = 1'b0;
    held_addr = a_address;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "a_valid held", 64'(a_valid), 64'd1);
      chk("R9", "opcode held", 64'(a_opcode), 64'd2);
      chk("R9", "address held", 64'(a_address), 64'(held_addr));
      @(negedge clk);
    end
    a_ready = 1'b1;
    @(negedge clk);
    a_ready = 1'b0;
    d_valid = 1'b1; d_data = 32'h77;
    @(negedge clk);
    d_valid = 1'b0;
    chk("R9", "response after stall", 64'(rsp_data), 64'h77);
    @(negedge clk);

    // R10/R8: early d_valid and a waiting next request
    set_req(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 4'hF, 32'h2000, 32'hBEEF);
    d_valid = 1'b1; d_data = 32'h1111;
    @(negedge clk);
    chk("R10", "A pending", 64'(a_valid), 64'd1);
    chk("R10", "early d not taken", 64'(d_ready), 64'd0);
    chk("R10", "no early response", 64'(rsp_valid), 64'd0);
    a_ready = 1'b1;
    @(negedge clk);
    chk("R8", "ready low in wait", 64'(req_ready), 64'd0);
    chk("R10", "d taken now", 64'(d_ready), 64'd1);
    @(negedge clk);
    chk("R10", "response strobe", 64'(rsp_valid), 64'd1);
    chk("R10", "response data", 64'(rsp_data), 64'h1111);
    chk("R8", "next request held off", 64'(req_ready), 64'd0);
    d_valid = 1'b0; a_ready = 1'b0;
    @(negedge clk);
    chk("R8", "next request accepted after strobe", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk("R8", "second A beat", 64'(a_valid), 64'd1);
    req_valid = 1'b0; a_ready = 1'b1;
    @(negedge clk);
    a_ready = 1'b0;
    chk("R8", "second wait", 64'(d_ready), 64'd1);
    d_valid = 1'b1; d_data = 32'h2222;
    @(negedge clk);
    d_valid = 1'b0;
    chk("R10", "second response", 64'(rsp_data), 64'h2222);
    @(negedge clk);
    chk("R8", "idle at end", 64'(req_ready), 64'd1);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule